// File: doc/BRIEF.md
# SDRAM Manual Command Sequencer

This block lets software drive an SDRAM device through a few write-strobe registers instead of the controller's normal scheduler. A write to one register produces a PRECHARGE ALL, a write to another produces an AUTO REFRESH, and a third register toggles self-refresh: its odd-numbered writes enter it and its even-numbered writes leave it. Every command goes to all chip selects that the enable mask selects at the moment the command is issued. Commands are offered to the memory command path with a valid signal and held until that path accepts them.

The block owns the clock-enable output. After a self-refresh command is accepted, the self-refresh status flag rises and clock enable drops. On exit, clock enable rises and a recovery window of (TXSR+1)*16 clocks holds off the next command. The logic reset models loss of the block's power domain. It clears the sequencer, the status flag and the write parity, but leaves clock enable where it was, so the memory keeps refreshing itself. The next self-refresh write then only re-synchronises the flag.

Requests that arrive while the sequencer is busy wait in a one-deep slot. A precharge or refresh that reaches the head of the queue while self-refresh is active is discarded, and a sticky error bit is set.

Top module: `sdram_manual_cmd_seq`

## Requirements
- R1: A write to address 0 (data is not used) yields exactly one command with code 1 (PRECHARGE ALL) on `cmd`. `cmd_cs` equals `cs_en` as sampled in the cycle the command is issued.
- R2: A write to address 1 yields exactly one command with code 2 (AUTO REFRESH), with `cmd_cs` taken from `cs_en` in the same way as R1.
- R3: `rd_data` shows `refresh_timer` when `rd_addr` is 1. When `rd_addr` is 3 it shows the status word, with `slf` in bit 0 and `err` in bit 1.
- R4: Odd-numbered writes to address 2 issue code 3 (SELF REFRESH) while `cke` is high. When that command is accepted, `slf` becomes 1 and `cke` becomes 0.
- R5: Even-numbered writes to address 2 put no command on the bus. They set `cke` to 1 and clear `slf`.
- R6: After `cke` rises on exit, `cmd_valid` stays low for (TXSR+1)*16 cycles. A waiting request appears exactly (TXSR+1)*16+1 cycles after the rise.
- R7: While `cmd_valid` is high and `cmd_accept` is low, `cmd_valid`, `cmd` and `cmd_cs` stay unchanged.
- R8: A request that arrives while a command is in flight is queued one deep and issued in arrival order. A further request that arrives while the slot is full is discarded and sets `err`.
- R9: A precharge or auto-refresh that reaches issue while `slf` is 1 is discarded with no command. `err` is set and stays set until reset, and `slf` is unchanged.
- R10: `rst` clears `slf`, `err`, the queue and the write parity, and leaves `cke` unchanged. `por` does the same and also forces `cke` to 1.
- R11: An entry write that reaches issue while `cke` is already low puts no command on the bus and sets `slf` to 1.
- R12: `busy` is high whenever a request is queued, a command awaits acceptance or the recovery window runs, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous logic reset (power-domain loss); keeps clock enable |
| por | input | 1 | Synchronous full reset; also raises clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 precharge, 1 refresh, 2 self-refresh toggle |
| rd_addr | input | 2 | Read address: 1 refresh timer, 3 status |
| rd_data | output | TIMER_W | Read data |
| refresh_timer | input | TIMER_W | Current value of the periodic refresh timer |
| cs_en | input | NCS | Enabled chip selects |
| txsr | input | 4 | Exit recovery field; wait is (txsr+1)*16 clocks |
| cmd_accept | input | 1 | Command path takes the offered command |
| cmd_valid | output | 1 | A command is offered |
| cmd | output | 2 | Command code: 0 none, 1 precharge all, 2 auto refresh, 3 self refresh |
| cmd_cs | output | NCS | Chip selects for the offered command |
| cke | output | 1 | SDRAM clock enable |
| slf | output | 1 | Self-refresh active flag |
| err | output | 1 | Sticky error: discarded request |
| busy | output | 1 | Queue, issue or recovery in progress |

## Verification
Precharge and refresh writes are mixed at random with random chip-select masks and accept delays. The mask is changed while a command waits for acceptance, which separates sampling at issue from following the input live. Back-to-back writes show whether the one-deep slot keeps arrival order and where it starts dropping. Self-refresh exits are timed with TXSR at 0, 2 and 15, so an off-by-one in the recovery count or in the multiply by 16 shows up. A logic reset is applied in the middle of self-refresh; the writes that follow show whether clock enable stayed low and whether the parity restarted with an entry.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

    localparam int ADDR_W     = 2;
    localparam int TXSR_W     = 4;
    localparam int REC_SHIFT  = 4;
    localparam int REC_W      = TXSR_W + REC_SHIFT;

    localparam logic [ADDR_W-1:0] REG_PRECHARGE = 2'd0;
    localparam logic [ADDR_W-1:0] REG_AUTOREF   = 2'd1;
    localparam logic [ADDR_W-1:0] REG_SELFREF   = 2'd2;
    localparam logic [ADDR_W-1:0] REG_STATUS    = 2'd3;

    typedef enum logic [1:0] {
        CMD_NONE          = 2'd0,
        CMD_PRECHARGE_ALL = 2'd1,
        CMD_AUTO_REFRESH  = 2'd2,
        CMD_SELF_REFRESH  = 2'd3
    } sdcmd_e;

    typedef enum logic [1:0] {
        REQ_PRE,
        REQ_AREF,
        REQ_SR_ENTER,
        REQ_SR_EXIT
    } req_e;

    // Last count value of the recovery window: (txsr+1)*2^REC_SHIFT - 1
    function automatic logic [REC_W-1:0] rec_last(input logic [TXSR_W-1:0] txsr);
        return {txsr, {REC_SHIFT{1'b1}}};
    endfunction

endpackage

// File: rtl/mcs_req_slot.sv
module mcs_req_slot
    import mcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              pop,
    output logic              q_valid,
    output req_e              q_kind,
    output logic              overflow
);
    logic is_req;
    logic slot_free;
    logic phase;        // 0: next self-refresh write enters, 1: it exits
    req_e new_kind;

    assign is_req    = wr_en && (wr_addr != REG_STATUS);
    assign slot_free = !q_valid || pop;

    always_comb begin
        unique case (wr_addr)
            REG_PRECHARGE: new_kind = REQ_PRE;
            REG_AUTOREF:   new_kind = REQ_AREF;
            default:       new_kind = phase ? REQ_SR_EXIT : REQ_SR_ENTER;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid  <= 1'b0;
            q_kind   <= REQ_PRE;
            phase    <= 1'b0;
            overflow <= 1'b0;
        end else begin
            overflow <= is_req && !slot_free;
            if (pop)
                q_valid <= 1'b0;
            if (is_req && slot_free) begin
                q_valid <= 1'b1;
                q_kind  <= new_kind;
                if (wr_addr == REG_SELFREF)
                    phase <= ~phase;
            end
        end
    end
endmodule

// File: rtl/mcs_exit_timer.sv
module mcs_exit_timer
    import mcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [TXSR_W-1:0] txsr,
    output logic              running
);
    logic [REC_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (start) begin
            cnt     <= rec_last(txsr);
            running <= 1'b1;
        end else if (running) begin
            if (cnt == '0)
                running <= 1'b0;
            else
                cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/sdram_manual_cmd_seq.sv
module sdram_manual_cmd_seq
    import mcs_pkg::*;
#(
    parameter int NCS     = 4,
    parameter int TIMER_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               por,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [1:0]         rd_addr,
    output logic [TIMER_W-1:0] rd_data,
    input  logic [TIMER_W-1:0] refresh_timer,
    input  logic [NCS-1:0]     cs_en,
    input  logic [3:0]         txsr,
    input  logic               cmd_accept,
    output logic               cmd_valid,
    output logic [1:0]         cmd,
    output logic [NCS-1:0]     cmd_cs,
    output logic               cke,
    output logic               slf,
    output logic               err,
    output logic               busy
);
    typedef enum logic {ST_IDLE, ST_ISSUE} st_e;

    logic     logic_rst;
    st_e      st;
    sdcmd_e   cmd_r;
    logic [NCS-1:0] cs_r;
    logic     slf_r, err_r, cke_r;
    logic     q_valid, overflow, rec_running;
    req_e     q_kind;
    logic     dispatch, rec_start, sr_done, drop;

    assign logic_rst = rst || por;

    mcs_req_slot u_slot (
        .clk      (clk),
        .rst      (logic_rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .pop      (dispatch),
        .q_valid  (q_valid),
        .q_kind   (q_kind),
        .overflow (overflow)
    );

    mcs_exit_timer u_timer (
        .clk     (clk),
        .rst     (logic_rst),
        .start   (rec_start),
        .txsr    (txsr),
        .running (rec_running)
    );

    assign dispatch  = (st == ST_IDLE) && q_valid && !rec_running;
    assign rec_start = dispatch && (q_kind == REQ_SR_EXIT);
    assign sr_done   = (st == ST_ISSUE) && cmd_accept && (cmd_r == CMD_SELF_REFRESH);
    assign drop      = dispatch && slf_r && ((q_kind == REQ_PRE) || (q_kind == REQ_AREF));

    always_ff @(posedge clk) begin
        if (logic_rst) begin
            st    <= ST_IDLE;
            cmd_r <= CMD_NONE;
            cs_r  <= '0;
            slf_r <= 1'b0;
            err_r <= 1'b0;
        end else begin
            err_r <= err_r | overflow | drop;
            if ((st == ST_ISSUE) && cmd_accept) begin
                st <= ST_IDLE;
                if (sr_done)
                    slf_r <= 1'b1;
            end
            if (dispatch) begin
                unique case (q_kind)
                    REQ_PRE: if (!slf_r) begin
                        st    <= ST_ISSUE;
                        cmd_r <= CMD_PRECHARGE_ALL;
                        cs_r  <= cs_en;
                    end
                    REQ_AREF: if (!slf_r) begin
                        st    <= ST_ISSUE;
                        cmd_r <= CMD_AUTO_REFRESH;
                        cs_r  <= cs_en;
                    end
                    REQ_SR_ENTER: if (!cke_r) begin
                        slf_r <= 1'b1;      // memory already self-refreshing
                    end else begin
                        st    <= ST_ISSUE;
                        cmd_r <= CMD_SELF_REFRESH;
                        cs_r  <= cs_en;
                    end
                    REQ_SR_EXIT: slf_r <= 1'b0;
                endcase
            end
        end
    end

    // Clock enable survives the logic reset; only the full reset raises it.
    always_ff @(posedge clk) begin
        if (por)
            cke_r <= 1'b1;
        else if (rec_start)
            cke_r <= 1'b1;
        else if (sr_done)
            cke_r <= 1'b0;
    end

    always_comb begin
        unique case (rd_addr)
            REG_AUTOREF: rd_data = refresh_timer;
            REG_STATUS:  rd_data = {{(TIMER_W-2){1'b0}}, err_r, slf_r};
            default:     rd_data = '0;
        endcase
    end

    assign cmd_valid = (st == ST_ISSUE);
    assign cmd       = cmd_valid ? cmd_r : CMD_NONE;
    assign cmd_cs    = cs_r;
    assign cke       = cke_r;
    assign slf       = slf_r;
    assign err       = err_r;
    assign busy      = (st != ST_IDLE) || q_valid || rec_running;
endmodule

// File: rtl/mcs_checker.sv
module mcs_checker #(
    parameter int NCS = 4
) (
    input logic           clk,
    input logic           rst,
    input logic           por,
    input logic           cmd_valid,
    input logic [1:0]     cmd,
    input logic [NCS-1:0] cmd_cs,
    input logic           cmd_accept,
    input logic           cke,
    input logic           slf,
    input logic           busy,
    input logic [3:0]     txsr
);
    logic       cke_q, por_q, cke_rose;
    logic [7:0] win;

    assign cke_rose = cke && !cke_q && !por_q;

    always_ff @(posedge clk) begin
        cke_q <= cke;
        por_q <= por;
        if (rst || por)
            win <= '0;
        else if (cke_rose)
            win <= {txsr, 4'hF} - 8'd1;
        else if (win != '0)
            win <= win - 1'b1;
    end

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst || por)
        cmd_valid && !cmd_accept |=> cmd_valid && $stable(cmd) && $stable(cmd_cs));

    assert_valid_code_R1: assert property (@(posedge clk) disable iff (rst || por)
        cmd_valid |-> cmd != 2'd0);

    assert_cke_drop_R4: assert property (@(posedge clk) disable iff (rst || por)
        $fell(cke) |-> slf);

    assert_slf_cke_low_R4: assert property (@(posedge clk) disable iff (rst || por)
        slf |-> !cke);

    assert_quiet_in_sr_R9: assert property (@(posedge clk) disable iff (rst || por)
        slf |-> !cmd_valid);

    assert_recovery_R6: assert property (@(posedge clk) disable iff (rst || por)
        (cke_rose || win != '0) |-> !cmd_valid);

    assert_busy_R12: assert property (@(posedge clk) disable iff (rst || por)
        cmd_valid |-> busy);
endmodule

bind sdram_manual_cmd_seq mcs_checker #(.NCS(NCS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .por        (por),
    .cmd_valid  (cmd_valid),
    .cmd        (cmd),
    .cmd_cs     (cmd_cs),
    .cmd_accept (cmd_accept),
    .cke        (cke),
    .slf        (slf),
    .busy       (busy),
    .txsr       (txsr)
);

// File: tb/sim_sdram_manual_cmd_seq.sv
`timescale 1ns/1ps
module sim_sdram_manual_cmd_seq;
    localparam int NCS     = 4;
    localparam int TIMER_W = 16;

    logic clk = 1'b0;
    logic rst = 1'b0, por = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_addr = '0, rd_addr = '0;
    logic [TIMER_W-1:0] rd_data, refresh_timer = '0;
    logic [NCS-1:0] cs_en = '0, cmd_cs;
    logic [3:0] txsr = '0;
    logic cmd_accept = 1'b0;
    logic cmd_valid, cke, slf, err, busy;
    logic [1:0] cmd;

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    sdram_manual_cmd_seq #(.NCS(NCS), .TIMER_W(TIMER_W)) u0 (
        .clk(clk), .rst(rst), .por(por), .wr_en(wr_en), .wr_addr(wr_addr),
        .rd_addr(rd_addr), .rd_data(rd_data), .refresh_timer(refresh_timer),
        .cs_en(cs_en), .txsr(txsr), .cmd_accept(cmd_accept),
        .cmd_valid(cmd_valid), .cmd(cmd), .cmd_cs(cmd_cs), .cke(cke),
        .slf(slf), .err(err), .busy(busy)
    );

    function automatic int exp_gap(input logic [3:0] tx);
        return (int'(tx) + 1) * 16 + 1;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a);
        wr_en = 1'b1; wr_addr = a;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic expect_cmd(input string req, input int code, input logic [NCS-1:0] cs, input int dly);
        int n = 0;
        while (!cmd_valid && n < 600) begin @(negedge clk); n++; end
        check({req, " valid"}, cmd_valid, 1);
        check({req, " code"}, cmd, code);
        check({req, " cs"}, cmd_cs, cs);
        cs_en = NCS'($urandom);
        for (int d = 0; d < dly; d++) begin
            @(negedge clk);
            check("R7 hold valid", cmd_valid, 1);
            check("R7 hold code", cmd, code);
            check("R7 hold cs", cmd_cs, cs);
        end
        cmd_accept = 1'b1;
        @(negedge clk);
        cmd_accept = 1'b0;
        check({req, " released"}, cmd_valid, 0);
    endtask

    task automatic enter_sr();
        cs_en = 4'b1011;
        wr(2'd2);
        expect_cmd("R4", 3, 4'b1011, 1);
        check("R4 slf", slf, 1);
        check("R4 cke", cke, 0);
    endtask

    task automatic exit_timed(input logic [3:0] tx);
        int k = 0;
        txsr = tx;
        cs_en = 4'b0110;
        wr(2'd2);
        wr(2'd1);
        check("R5 cke", cke, 1);
        check("R5 slf", slf, 0);
        check("R12 busy in recovery", busy, 1);
        check("R5 no cmd", cmd_valid, 0);
        while (!cmd_valid && k < 400) begin @(negedge clk); k++; end
        check("R6 gap", k, exp_gap(tx));
        expect_cmd("R6 waiting refresh", 2, 4'b0110, 0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd1234));
        por = 1'b1; rst = 1'b1;
        repeat (3) @(negedge clk);
        por = 1'b0; rst = 1'b0;
        @(negedge clk);
        check("R10 reset cke", cke, 1);
        check("R10 reset slf", slf, 0);
        check("R10 reset err", err, 0);
        check("R10 reset valid", cmd_valid, 0);
        check("R12 idle busy", busy, 0);

        // random precharge / refresh traffic
        for (int i = 0; i < 24; i++) begin
            logic [NCS-1:0] cs = NCS'($urandom);
            bit is_ref = $urandom_range(0, 1) == 1;
            cs_en = cs;
            wr(is_ref ? 2'd1 : 2'd0);
            check("R12 busy queued", busy, 1);
            expect_cmd(is_ref ? "R2" : "R1", is_ref ? 2 : 1, cs, $urandom_range(0, 3));
            check("R12 busy cleared", busy, 0);
        end

        // reads
        for (int i = 0; i < 4; i++) begin
            refresh_timer = TIMER_W'($urandom);
            rd_addr = 2'd1; #1;
            check("R3 timer read", rd_data, refresh_timer);
        end
        rd_addr = 2'd3; #1;
        check("R3 status idle", rd_data, 0);

        // queue order and overflow
        cs_en = 4'b0101;
        wr(2'd0); wr(2'd1); wr(2'd0);
        expect_cmd("R8 first", 1, 4'b0101, 2);
        cs_en = 4'b0101;
        expect_cmd("R8 second", 2, 4'b0101, 0);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R8 third dropped", cmd_valid, 0);
        end
        check("R8 overflow err", err, 1);
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        check("R10 err cleared", err, 0);
        check("R10 cke kept high", cke, 1);

        // self refresh entry, blocked commands, timed exits
        enter_sr();
        rd_addr = 2'd3; #1;
        check("R3 status slf", rd_data, 1);
        wr(2'd0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R9 no cmd", cmd_valid, 0);
        end
        check("R9 err", err, 1);
        check("R9 slf kept", slf, 1);
        rd_addr = 2'd3; #1;
        check("R3 status err slf", rd_data, 3);
        exit_timed(4'd2);
        check("R9 err sticky", err, 1);
        enter_sr();
        exit_timed(4'd0);
        enter_sr();
        exit_timed(4'd15);

        // power-domain loss during self refresh
        enter_sr();
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        check("R10 slf cleared", slf, 0);
        check("R10 cke stays low", cke, 0);
        wr(2'd2);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R11 no cmd", cmd_valid, 0);
        end
        check("R11 slf", slf, 1);
        check("R11 cke", cke, 0);
        exit_timed(4'd1);

        done = 1;
        finish_run();
    end
endmodule